// File: doc/BRIEF.md
# IPv4 Receive Header Parser

This block sits behind an Ethernet receive MAC and takes the frame one byte per clock on an AXI4-Stream style slave port. It walks the fixed 14-byte link header and the fixed 20-byte IPv4 header, capturing the frame type, the version/header-length byte, the total length, the protocol, the source address and the destination address. A frame is accepted when its type is IPv4 and its destination address matches the configured local address. An accepted frame's payload bytes are then forwarded, one clock later, on a plain data/valid/last interface together with a header-valid flag, a start pulse and the captured header fields.

Frames that are not IPv4 or that are for another station are skipped silently to their last byte. Malformed frames are also skipped, but they bump a saturating error counter and record an error code. A separate counter tracks the accepted packets. The parser never applies back-pressure. Header options, fragment reassembly and checksum checking are not handled.

Top module: `ipv4_rx_parser`

## Requirements
- R1: While and after reset, every output is zero (payload data, valid, last and start, header-valid, protocol, length, source address, error count, error code and packet count), except the ready output.
- R2: Input bytes are taken in this order: destination MAC (bytes 0-5), source MAC (6-11), type (12-13, most significant byte first), version/IHL (14), service type (15), total length (16-17, most significant first), ID (18-19), flags/fragment (20-21), TTL (22), protocol (23), checksum (24-25), source IP (26-29) and destination IP (30-33), each most significant byte first. Payload starts at byte 34.
- R3: The reported payload length is the total length minus 20 (a total length of 0x0018 reports 4).
- R4: Each output is registered and appears one clock after its input byte. On the output cycle of the first payload byte, payload-valid, start and header-valid are all high, and protocol, source address and length already hold the new frame's values. Header-valid goes low one clock after the first byte of the next frame is taken.
- R5: Payload-last is high on the output cycle of the byte that carried the input last flag, and start is high only for the first payload byte.
- R6: A clock without input valid gives a clock with payload-valid, payload-last and start all low, both between frames and inside a payload.
- R7: A frame whose type is not 0x0800, or whose destination IP differs from the local address, produces no payload output, leaves the error count, error code and packet count unchanged, and is skipped up to its last flag.
- R8: A frame whose last flag arrives on any of its first 34 bytes adds one to the error count and sets the error code to 1; the next byte is treated as the start of a new frame.
- R9: An IPv4-typed frame whose version/IHL byte is not 0x45 adds one to the error count, sets the error code to 2 and is skipped.
- R10: An IPv4-typed frame with version/IHL 0x45 and a total length below 20 adds one to the error count, sets the error code to 3 and is skipped. The type is checked first, then version/IHL, then length, then destination.
- R11: The 8-bit error count saturates at 255.
- R12: The 8-bit packet count rises by one, in the cycle that start is high, for each accepted frame, and wraps from 255 to 0.
- R13: The ready output is always high.
- R14: A frame without errors leaves the error count and error code unchanged, at zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_ip | input | 32 | Address this station answers to |
| s_tdata | input | 8 | Received frame byte |
| s_tvalid | input | 1 | Byte on s_tdata is valid |
| s_tlast | input | 1 | Byte is the last of its frame |
| s_tready | output | 1 | Always high |
| pl_data | output | 8 | Payload byte |
| pl_valid | output | 1 | pl_data holds a payload byte |
| pl_last | output | 1 | Final payload byte of the frame |
| pl_start | output | 1 | First payload byte of the frame |
| hdr_valid | output | 1 | Header fields belong to the frame being delivered |
| hdr_protocol | output | 8 | Captured protocol number |
| hdr_length | output | 16 | Payload length (total length minus 20) |
| hdr_src_ip | output | 32 | Captured source address |
| err_count | output | 8 | Saturating count of malformed frames |
| err_code | output | 4 | Code of the most recent error (1 runt, 2 version, 3 length) |
| pkt_count | output | 8 | Wrapping count of accepted frames |

## Verification
The main path is driven with a table of frames. It holds accepted frames with different protocols, source addresses and payload lengths, including a one-byte payload, so field capture and the length arithmetic are seen at several values. It also holds a non-IPv4 type, a foreign destination, a bad version byte and a too-short total length. These show silent skipping apart from counted errors, and show each error code apart from the others. Directed frames follow: runts ending at byte 5 and at byte 34 exercise the runt edge, and an idle cycle inside a payload shows that output gaps follow input gaps. Long runs of runts and accepted frames drive the error count into saturation and the packet count through its wrap.

// File: rtl/ipv4_rx_pkg.sv
package ipv4_rx_pkg;

  // Fixed layout of a frame carrying an option-free IPv4 header
  localparam int IP_HDR_BYTES  = 20;
  localparam int HDR_BYTES     = 34;
  localparam int OFF_TYPE_HI   = 12;
  localparam int OFF_TYPE_LO   = 13;
  localparam int OFF_VIHL      = 14;
  localparam int OFF_TOTLEN_HI = 16;
  localparam int OFF_TOTLEN_LO = 17;
  localparam int OFF_PROTO     = 23;
  localparam int OFF_SRC       = 26;
  localparam int OFF_DST       = 30;

  localparam logic [15:0] ETHERTYPE_IPV4 = 16'h0800;
  localparam logic [7:0]  VIHL_PLAIN     = 8'h45;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_PAY,
    ST_SKIP
  } walk_st_e;

  typedef enum logic [3:0] {
    ERR_NONE    = 4'd0,
    ERR_RUNT    = 4'd1,
    ERR_VERSION = 4'd2,
    ERR_LENGTH  = 4'd3
  } rx_err_e;

endpackage

// File: rtl/ipv4_rx_walker.sv
module ipv4_rx_walker
  import ipv4_rx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] local_ip,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              pay_fire,
  output logic              pay_first,
  output logic              pay_last,
  output logic              frame_begin,
  output logic              err_fire,
  output rx_err_e           err_kind,
  output logic [7:0]        cap_proto,
  output logic [ADDR_W-1:0] cap_src,
  output logic [LEN_W-1:0]  cap_len
);

  localparam int IDX_W  = $clog2(HDR_BYTES + 1);
  localparam int ABYTES = ADDR_W / 8;
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(HDR_BYTES - 1);

  walk_st_e          st_q, st_d;
  logic [IDX_W-1:0]  idx_q;
  logic              first_q;
  logic              go;
  logic              hdr_hit;
  logic [15:0]       etype_q;
  logic [7:0]        vihl_q;
  logic [LEN_W-1:0]  tot_q;
  logic [7:0]        proto_q;
  logic [ADDR_W-9:0] dst_hi;
  logic [ADDR_W-1:0] dst_full;

  assign hdr_hit     = in_valid && (st_q == ST_HDR);
  assign frame_begin = hdr_hit && (idx_q == '0);
  assign pay_fire    = in_valid && (st_q == ST_PAY);
  assign pay_first   = pay_fire && first_q;
  assign pay_last    = pay_fire && in_last;
  assign dst_full    = {dst_hi, in_data};

  // Verdict logic: decided on the final header byte, runt on any header byte
  always_comb begin
    st_d     = st_q;
    err_fire = 1'b0;
    err_kind = ERR_NONE;
    go       = 1'b0;
    unique case (st_q)
      ST_HDR: begin
        if (in_valid) begin
          if (in_last) begin
            err_fire = 1'b1;
            err_kind = ERR_RUNT;
          end else if (idx_q == IDX_END) begin
            if (etype_q != ETHERTYPE_IPV4) begin
              st_d = ST_SKIP;
            end else if (vihl_q != VIHL_PLAIN) begin
              st_d     = ST_SKIP;
              err_fire = 1'b1;
              err_kind = ERR_VERSION;
            end else if (tot_q < LEN_W'(IP_HDR_BYTES)) begin
              st_d     = ST_SKIP;
              err_fire = 1'b1;
              err_kind = ERR_LENGTH;
            end else if (dst_full != local_ip) begin
              st_d = ST_SKIP;
            end else begin
              st_d = ST_PAY;
              go   = 1'b1;
            end
          end
        end
      end
      ST_PAY, ST_SKIP: begin
        if (in_valid && in_last) st_d = ST_HDR;
      end
      default: st_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_HDR;
      idx_q   <= '0;
      first_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (hdr_hit) begin
        idx_q <= (in_last || idx_q == IDX_END) ? '0 : idx_q + 1'b1;
      end
      if (go) begin
        first_q <= 1'b1;
      end else if (pay_fire) begin
        first_q <= 1'b0;
      end
    end
  end

  // Single-byte fields
  always_ff @(posedge clk) begin
    if (rst) begin
      etype_q <= '0;
      vihl_q  <= '0;
      tot_q   <= '0;
      proto_q <= '0;
    end else if (hdr_hit) begin
      if (idx_q == IDX_W'(OFF_TYPE_HI))   etype_q[15:8] <= in_data;
      if (idx_q == IDX_W'(OFF_TYPE_LO))   etype_q[7:0]  <= in_data;
      if (idx_q == IDX_W'(OFF_VIHL))      vihl_q        <= in_data;
      if (idx_q == IDX_W'(OFF_TOTLEN_HI)) tot_q         <= {in_data, tot_q[7:0]};
      if (idx_q == IDX_W'(OFF_TOTLEN_LO)) tot_q         <= {tot_q[LEN_W-1:8], in_data};
      if (idx_q == IDX_W'(OFF_PROTO))     proto_q       <= in_data;
    end
  end

  // Address bytes, most significant first
  for (genvar k = 0; k < ABYTES; k++) begin : g_addr
    logic [7:0] src_byte;
    always_ff @(posedge clk) begin
      if (rst) begin
        src_byte <= '0;
      end else if (hdr_hit && idx_q == IDX_W'(OFF_SRC + k)) begin
        src_byte <= in_data;
      end
    end
    assign cap_src[ADDR_W-1-8*k -: 8] = src_byte;

    if (k < ABYTES - 1) begin : g_dst
      logic [7:0] dst_byte;
      always_ff @(posedge clk) begin
        if (rst) begin
          dst_byte <= '0;
        end else if (hdr_hit && idx_q == IDX_W'(OFF_DST + k)) begin
          dst_byte <= in_data;
        end
      end
      assign dst_hi[ADDR_W-9-8*k -: 8] = dst_byte;
    end
  end

  assign cap_proto = proto_q;
  assign cap_len   = tot_q - LEN_W'(IP_HDR_BYTES);

endmodule

// File: rtl/ipv4_rx_stats.sv
module ipv4_rx_stats
  import ipv4_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_fire,
  input  rx_err_e          err_kind,
  input  logic             pkt_inc,
  output logic [CNT_W-1:0] err_count,
  output logic [3:0]       err_code,
  output logic [CNT_W-1:0] pkt_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      err_count <= '0;
      err_code  <= '0;
      pkt_count <= '0;
    end else begin
      if (err_fire) begin
        err_code <= err_kind;
        if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
      end
      if (pkt_inc) pkt_count <= pkt_count + 1'b1;
    end
  end

endmodule

// File: rtl/ipv4_rx_out.sv
module ipv4_rx_out #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        in_data,
  input  logic              pay_fire,
  input  logic              pay_first,
  input  logic              pay_last,
  input  logic              frame_begin,
  input  logic [7:0]        cap_proto,
  input  logic [ADDR_W-1:0] cap_src,
  input  logic [LEN_W-1:0]  cap_len,
  output logic [7:0]        pl_data,
  output logic              pl_valid,
  output logic              pl_last,
  output logic              pl_start,
  output logic              hdr_valid,
  output logic [7:0]        hdr_protocol,
  output logic [LEN_W-1:0]  hdr_length,
  output logic [ADDR_W-1:0] hdr_src_ip
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pl_data  <= '0;
      pl_valid <= 1'b0;
      pl_last  <= 1'b0;
      pl_start <= 1'b0;
    end else begin
      pl_valid <= pay_fire;
      pl_last  <= pay_last;
      pl_start <= pay_first;
      if (pay_fire) pl_data <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_valid    <= 1'b0;
      hdr_protocol <= '0;
      hdr_length   <= '0;
      hdr_src_ip   <= '0;
    end else begin
      if (pay_first) begin
        hdr_valid    <= 1'b1;
        hdr_protocol <= cap_proto;
        hdr_length   <= cap_len;
        hdr_src_ip   <= cap_src;
      end else if (frame_begin) begin
        hdr_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ipv4_rx_parser.sv
module ipv4_rx_parser
  import ipv4_rx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] local_ip,
  input  logic [7:0]        s_tdata,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  output logic              s_tready,
  output logic [7:0]        pl_data,
  output logic              pl_valid,
  output logic              pl_last,
  output logic              pl_start,
  output logic              hdr_valid,
  output logic [7:0]        hdr_protocol,
  output logic [LEN_W-1:0]  hdr_length,
  output logic [ADDR_W-1:0] hdr_src_ip,
  output logic [CNT_W-1:0]  err_count,
  output logic [3:0]        err_code,
  output logic [CNT_W-1:0]  pkt_count
);

  logic              pay_fire, pay_first, pay_last, frame_begin, err_fire;
  rx_err_e           err_kind;
  logic [7:0]        cap_proto;
  logic [ADDR_W-1:0] cap_src;
  logic [LEN_W-1:0]  cap_len;

  assign s_tready = 1'b1;

  ipv4_rx_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst(rst), .local_ip(local_ip),
    .in_data(s_tdata), .in_valid(s_tvalid), .in_last(s_tlast),
    .pay_fire(pay_fire), .pay_first(pay_first), .pay_last(pay_last),
    .frame_begin(frame_begin), .err_fire(err_fire), .err_kind(err_kind),
    .cap_proto(cap_proto), .cap_src(cap_src), .cap_len(cap_len)
  );

  ipv4_rx_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst), .err_fire(err_fire), .err_kind(err_kind),
    .pkt_inc(pay_first), .err_count(err_count), .err_code(err_code),
    .pkt_count(pkt_count)
  );

  ipv4_rx_out #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_out (
    .clk(clk), .rst(rst), .in_data(s_tdata),
    .pay_fire(pay_fire), .pay_first(pay_first), .pay_last(pay_last),
    .frame_begin(frame_begin), .cap_proto(cap_proto), .cap_src(cap_src),
    .cap_len(cap_len), .pl_data(pl_data), .pl_valid(pl_valid),
    .pl_last(pl_last), .pl_start(pl_start), .hdr_valid(hdr_valid),
    .hdr_protocol(hdr_protocol), .hdr_length(hdr_length),
    .hdr_src_ip(hdr_src_ip)
  );

endmodule

// File: rtl/ipv4_rx_parser_chk.sv
module ipv4_rx_parser_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             s_tvalid,
  input logic             s_tlast,
  input logic             pl_valid,
  input logic             pl_last,
  input logic             pl_start,
  input logic             hdr_valid,
  input logic [CNT_W-1:0] err_count,
  input logic [3:0]       err_code,
  input logic [CNT_W-1:0] pkt_count
);

  p_start_hdr_r4: assert property (@(posedge clk) disable iff (rst)
    pl_start |-> (pl_valid && hdr_valid));

  p_last_valid_r5: assert property (@(posedge clk) disable iff (rst)
    pl_last |-> pl_valid);

  p_last_from_input_r5: assert property (@(posedge clk) disable iff (rst)
    pl_last |-> $past(s_tlast));

  p_valid_from_input_r6: assert property (@(posedge clk) disable iff (rst)
    pl_valid |-> $past(s_tvalid));

  p_err_step_r11: assert property (@(posedge clk) disable iff (rst)
    (err_count != $past(err_count)) |-> (err_count == $past(err_count) + CNT_W'(1)));

  p_err_code_set_r8: assert property (@(posedge clk) disable iff (rst)
    (err_count != $past(err_count)) |-> (err_code != 4'd0));

  p_pkt_on_start_r12: assert property (@(posedge clk) disable iff (rst)
    (pkt_count != $past(pkt_count)) |-> pl_start);

  p_start_counts_r12: assert property (@(posedge clk) disable iff (rst)
    pl_start |-> (pkt_count == $past(pkt_count) + CNT_W'(1)));

endmodule

bind ipv4_rx_parser ipv4_rx_parser_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
  .pl_valid(pl_valid), .pl_last(pl_last), .pl_start(pl_start),
  .hdr_valid(hdr_valid), .err_count(err_count), .err_code(err_code),
  .pkt_count(pkt_count)
);

// File: tb/tb_ipv4_rx_parser.sv
module tb_ipv4_rx_parser;

  localparam logic [31:0] LOCAL_IP = 32'hC0A80509;

  typedef struct packed {
    logic [15:0] et;
    logic [7:0]  vihl;
    logic [15:0] tot;
    logic [7:0]  proto;
    logic [31:0] src;
    logic [31:0] dst;
    logic [7:0]  npay;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0800, 8'h45, 16'h0018, 8'h11, 32'hC0A80501, LOCAL_IP,     8'd4},
    '{16'h0800, 8'h45, 16'h001B, 8'h06, 32'h0A000001, LOCAL_IP,     8'd7},
    '{16'h0806, 8'h45, 16'h001C, 8'h11, 32'hC0A80501, LOCAL_IP,     8'd8},
    '{16'h0800, 8'h45, 16'h0018, 8'h11, 32'hC0A80501, 32'hC0A8050A, 8'd4},
    '{16'h0800, 8'h46, 16'h0018, 8'h11, 32'hC0A80501, LOCAL_IP,     8'd4},
    '{16'h0800, 8'h45, 16'h0010, 8'h11, 32'hC0A80501, LOCAL_IP,     8'd2},
    '{16'h0800, 8'h45, 16'h0015, 8'hFF, 32'hFFFFFFFF, LOCAL_IP,     8'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tlast = 1'b0;
  logic        s_tready;
  logic [7:0]  pl_data;
  logic        pl_valid, pl_last, pl_start, hdr_valid;
  logic [7:0]  hdr_protocol;
  logic [15:0] hdr_length;
  logic [31:0] hdr_src_ip;
  logic [7:0]  err_count;
  logic [3:0]  err_code;
  logic [7:0]  pkt_count;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] exp_err  = '0;
  logic [3:0] exp_code = '0;
  logic [7:0] exp_pkt  = '0;

  always #10 clk = ~clk;

  ipv4_rx_parser dut (
    .clk(clk), .rst(rst), .local_ip(LOCAL_IP),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
    .s_tready(s_tready), .pl_data(pl_data), .pl_valid(pl_valid),
    .pl_last(pl_last), .pl_start(pl_start), .hdr_valid(hdr_valid),
    .hdr_protocol(hdr_protocol), .hdr_length(hdr_length),
    .hdr_src_ip(hdr_src_ip), .err_count(err_count), .err_code(err_code),
    .pkt_count(pkt_count)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] frame_byte(input int i, input vec_t f);
    case (i)
      12: return f.et[15:8];
      13: return f.et[7:0];
      14: return f.vihl;
      16: return f.tot[15:8];
      17: return f.tot[7:0];
      22: return 8'h40;
      23: return f.proto;
      26: return f.src[31:24];
      27: return f.src[23:16];
      28: return f.src[15:8];
      29: return f.src[7:0];
      30: return f.dst[31:24];
      31: return f.dst[23:16];
      32: return f.dst[15:8];
      33: return f.dst[7:0];
      default: return (i >= 34) ? 8'(8'hA0 + (i - 34)) : 8'(i + 1);
    endcase
  endfunction

  task automatic bump_err(input logic [3:0] code);
    if (exp_err != 8'hFF) exp_err = exp_err + 8'd1;
    exp_code = code;
  endtask

  // Sends one full frame; kind 0 accept, 1 silent skip, 2/3 error code
  task automatic send_frame(input vec_t f, input bit gap, input bit quiet);
    int kind;
    int n;
    bit stray;
    n = 34 + int'(f.npay);
    stray = 1'b0;
    if (f.et != 16'h0800)        kind = 1;
    else if (f.vihl != 8'h45)    kind = 2;
    else if (f.tot < 16'd20)     kind = 3;
    else if (f.dst != LOCAL_IP)  kind = 1;
    else                         kind = 0;
    for (int i = 0; i < n; i++) begin
      if (gap && kind == 0 && i == 35) begin
        s_tvalid = 1'b0;
        @(negedge clk);
        chk(!pl_valid && !pl_start && !pl_last, "R6 gap inside payload", {pl_valid, pl_start, pl_last}, 0);
      end
      s_tdata  = frame_byte(i, f);
      s_tvalid = 1'b1;
      s_tlast  = (i == n - 1);
      @(negedge clk);
      if (kind == 0 && i >= 34) begin
        if (!quiet || i == 34) begin
          chk(pl_valid && pl_data == frame_byte(i, f), "R2 payload byte", {pl_valid, pl_data}, {1'b1, frame_byte(i, f)});
          chk(pl_start == (i == 34), "R5 start only on first byte", pl_start, (i == 34));
          chk(pl_last == (i == n - 1), "R5 last with input last", pl_last, (i == n - 1));
        end
        if (i == 34) begin
          chk(hdr_valid, "R4 header valid on first payload", hdr_valid, 1);
          chk(hdr_protocol == f.proto && hdr_src_ip == f.src, "R4 protocol and source",
              {hdr_protocol, hdr_src_ip}, {f.proto, f.src});
          chk(hdr_length == f.tot - 16'd20, "R3 payload length", hdr_length, f.tot - 16'd20);
          chk(pkt_count == exp_pkt + 8'd1, "R12 packet count", pkt_count, exp_pkt + 8'd1);
        end
      end else begin
        if (pl_valid || pl_start || pl_last) stray = 1'b1;
        if (i == 0 && !quiet) chk(!hdr_valid, "R4 header valid drops at next frame", hdr_valid, 0);
      end
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
    if (kind == 0) exp_pkt = exp_pkt + 8'd1;
    if (kind >= 2) bump_err(4'(kind));
    @(negedge clk);
    if (!quiet) begin
      chk(!stray, (kind == 1) ? "R7 no output for skipped frame" :
                  (kind == 2) ? "R9 no output for bad version" :
                  (kind == 3) ? "R10 no output for short length" : "R4 no output during header",
          stray, 0);
      chk(!pl_valid && !pl_last && !pl_start, "R6 outputs drop after frame", {pl_valid, pl_last, pl_start}, 0);
      chk(err_count == exp_err && err_code == exp_code,
          (kind == 0) ? "R14 clean frame leaves errors" :
          (kind == 1) ? "R7 skip leaves errors" :
          (kind == 2) ? "R9 version error" : "R10 length error",
          {err_count, err_code}, {exp_err, exp_code});
      chk(pkt_count == exp_pkt, (kind == 0) ? "R12 packet count after frame" : "R7 packet count unchanged",
          pkt_count, exp_pkt);
    end
  endtask

  task automatic send_runt(input int n, input bit quiet);
    vec_t f;
    f = VECS[0];
    for (int i = 0; i < n; i++) begin
      s_tdata  = frame_byte(i, f);
      s_tvalid = 1'b1;
      s_tlast  = (i == n - 1);
      @(negedge clk);
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
    bump_err(4'd1);
    @(negedge clk);
    if (!quiet) begin
      chk(err_count == exp_err && err_code == exp_code, "R8 runt frame error",
          {err_count, err_code}, {exp_err, exp_code});
      chk(!pl_valid && pkt_count == exp_pkt, "R8 runt gives no output", {pl_valid, pkt_count}, {1'b0, exp_pkt});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] pkt_before;
    repeat (4) @(negedge clk);
    chk(pl_data == 0 && !pl_valid && !pl_last && !pl_start && !hdr_valid, "R1 payload outputs in reset",
        {pl_data, pl_valid, pl_last, pl_start, hdr_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(hdr_protocol == 0 && hdr_length == 0 && hdr_src_ip == 0, "R1 header fields after reset",
        {hdr_protocol, hdr_length, hdr_src_ip}, 0);
    chk(err_count == 0 && err_code == 0 && pkt_count == 0, "R1 counters after reset",
        {err_count, err_code, pkt_count}, 0);
    chk(s_tready, "R13 ready high", s_tready, 1);

    // Table of frames
    for (int v = 0; v < NVEC; v++) send_frame(VECS[v], 1'b0, 1'b0);

    // Runts at both ends of the header, then resynchronisation
    send_runt(5, 1'b0);
    send_runt(34, 1'b0);
    send_frame(VECS[0], 1'b0, 1'b0);

    // Idle cycle inside a payload
    send_frame(VECS[1], 1'b1, 1'b0);
    chk(s_tready, "R13 ready still high", s_tready, 1);

    // Saturate the error counter
    for (int r = 0; r < 260; r++) send_runt(1, 1'b1);
    @(negedge clk);
    chk(err_count == 8'hFF && exp_err == 8'hFF, "R11 error count saturates", err_count, 8'hFF);
    send_runt(2, 1'b0);

    // Wrap the packet counter
    pkt_before = pkt_count;
    for (int p = 0; p < 256; p++) send_frame(VECS[6], 1'b0, 1'b1);
    chk(pkt_count == pkt_before && pkt_count == exp_pkt, "R12 packet count wraps", pkt_count, pkt_before);
    send_frame(VECS[0], 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule